// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers event pulses from a USB device core into register-mapped interrupt state and drives one level interrupt. Each pulse on a main event input sets a sticky bit in a 32-bit main status register. Software clears a bit by writing 1 to its position. A matching main enable register selects which status bits can raise the interrupt output.

Acknowledge events from the data endpoints go to a second sticky register with one bit per endpoint. That register has its own enable register and its own write-1-to-clear. The OR of the endpoint bits that are both pending and enabled appears as one summary bit in the main status register. That summary bit is not stored. It drops by itself once software clears or masks the endpoint bits behind it.

Main status layout (bit: event):
- 0: setup received
- 1: control OUT ack/stall
- 2: control OUT nak
- 3: control IN ack/stall
- 4: control IN nak
- 5: hub status-change IN ack
- 6: bus reset
- 7: bus suspend
- 8: suspend/resume change
- 9 to 15: downstream ports 1 to 7
- 16: endpoint ack summary
- 17: endpoint nak
- 18 to 31: reserved

Top module: `usbd_irq_agg`

## Requirements
- R1: After reset, all four registers read 0 and irq_o is low.
- R2: A 1 on main_evt_i in bit positions 0 to 15 or 17 sets that bit of main status one clock later. The bit stays set until it is cleared.
- R3: A write to main status (addr 0) clears every bit where wdata_i is 1. Bits where wdata_i is 0 keep their value.
- R4: Bit 18 and bits 31:19 of main status and main enable always read 0. This holds even after event pulses or all-ones writes to those positions. Input bit 16 of main_evt_i has no effect.
- R5: A 1 on ep_evt_i[k] sets bit k of endpoint status (addr 2). A write to addr 2 clears exactly the bits where wdata_i is 1. Bits at or above N_EP read 0.
- R6: Main status bit 16 reads 1 exactly while (endpoint status AND endpoint enable) is nonzero. A write-1 to main bit 16 does not change it.
- R7: irq_o is high exactly while (main status read value AND main enable) is nonzero.
- R8: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit is 1 afterwards. This applies to both status registers.
- R9: Main enable (addr 1) holds the written value for bits 17:0. Endpoint enable (addr 3) holds the written value for bits N_EP-1:0. Writes take effect at the next clock.
- R10: rdata_o shows the register selected by addr_i in the same cycle (0 main status, 1 main enable, 2 endpoint status, 3 endpoint enable). A write changes the register at the next rising clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_evt_i | input | 32 | Event pulses for main status bits |
| ep_evt_i | input | N_EP | Endpoint ack event pulses |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of selected register |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench goes after four corner cases:
- Set and clear of the same bit in one cycle. A design where clear wins would drop the event.
- All-ones writes and events on reserved positions. Storage left on bit 18 or above would read back nonzero.
- The summary bit:
  - It must fall by itself when its endpoint bits are cleared or disabled. A stored summary would stay high.
  - It must not be clearable through main status.
- Zero bits in a clear write. A full-register clear would wipe pending events the write did not name.

Random events and writes, checked against a bench model, cover the rest of the register map and the interrupt gating.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned SUM_BIT = 16;
  localparam int unsigned RSV_BIT = 18;
  localparam logic [REG_W-1:0] EN_MASK   = (32'h1 << RSV_BIT) - 32'h1;
  localparam logic [REG_W-1:0] STAT_MASK = EN_MASK & ~(32'h1 << SUM_BIT);

  typedef enum logic [1:0] {
    A_STAT   = 2'd0,
    A_EN     = 2'd1,
    A_EPSTAT = 2'd2,
    A_EPEN   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usbd_irq_w1c.sv
module usbd_irq_w1c #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q_o[i] <= 1'b0;
        else if (set_i[i]) q_o[i] <= 1'b1;  // set wins over clear
        else if (clr_i[i]) q_o[i] <= 1'b0;
      end
    end else begin : g_rsv
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usbd_irq_rw.sv
module usbd_irq_rw #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q_o[i] <= 1'b0;
        else if (we_i) q_o[i] <= d_i[i];
      end
    end else begin : g_rsv
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usbd_irq_agg.sv
module usbd_irq_agg
  import usbd_irq_pkg::*;
#(
  parameter int unsigned N_EP = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      main_evt_i,
  input  logic [N_EP-1:0]  ep_evt_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o
);
  localparam logic [N_EP-1:0] EP_MASK = '1;

  logic            wr_stat, wr_en, wr_epstat, wr_epen;
  logic [31:0]     main_stat_q, main_en_q, main_rd;
  logic [N_EP-1:0] ep_stat_q, ep_en_q;
  logic            ep_sum;

  assign wr_stat   = we_i && (addr_i == A_STAT);
  assign wr_en     = we_i && (addr_i == A_EN);
  assign wr_epstat = we_i && (addr_i == A_EPSTAT);
  assign wr_epen   = we_i && (addr_i == A_EPEN);

  usbd_irq_w1c #(.W(32), .MASK(STAT_MASK)) u_main_stat (
    .clk_i, .rst_ni,
    .set_i (main_evt_i),
    .clr_i (wr_stat ? wdata_i : 32'h0),
    .q_o   (main_stat_q)
  );

  usbd_irq_rw #(.W(32), .MASK(EN_MASK)) u_main_en (
    .clk_i, .rst_ni,
    .we_i  (wr_en),
    .d_i   (wdata_i),
    .q_o   (main_en_q)
  );

  usbd_irq_w1c #(.W(N_EP), .MASK(EP_MASK)) u_ep_stat (
    .clk_i, .rst_ni,
    .set_i (ep_evt_i),
    .clr_i (wr_epstat ? wdata_i[N_EP-1:0] : '0),
    .q_o   (ep_stat_q)
  );

  usbd_irq_rw #(.W(N_EP), .MASK(EP_MASK)) u_ep_en (
    .clk_i, .rst_ni,
    .we_i  (wr_epen),
    .d_i   (wdata_i[N_EP-1:0]),
    .q_o   (ep_en_q)
  );

  // summary bit is derived, never stored
  assign ep_sum  = |(ep_stat_q & ep_en_q);
  assign main_rd = main_stat_q | (32'(ep_sum) << SUM_BIT);
  assign irq_o   = |(main_rd & main_en_q);

  always_comb begin
    unique case (addr_i)
      A_STAT:   rdata_o = main_rd;
      A_EN:     rdata_o = main_en_q;
      A_EPSTAT: rdata_o = 32'(ep_stat_q);
      default:  rdata_o = 32'(ep_en_q);
    endcase
  end
endmodule

// File: rtl/usbd_irq_agg_chk.sv
module usbd_irq_agg_chk
  import usbd_irq_pkg::*;
#(
  parameter int unsigned N_EP = 21
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [31:0]     main_evt_i,
  input logic [N_EP-1:0] ep_evt_i,
  input logic            we_i,
  input logic [1:0]      addr_i,
  input logic [31:0]     wdata_i,
  input logic            irq_o,
  input logic [31:0]     main_rd,
  input logic [31:0]     main_en_q,
  input logic [N_EP-1:0] ep_stat_q,
  input logic [N_EP-1:0] ep_en_q
);
  // R2
  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(main_evt_i & STAT_MASK) |=>
      ((main_rd & $past(main_evt_i & STAT_MASK)) == $past(main_evt_i & STAT_MASK)));

  // R3
  a_r3_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT) |=>
      ((main_rd & $past(main_rd & ~wdata_i & STAT_MASK)) ==
       $past(main_rd & ~wdata_i & STAT_MASK)));

  // R4
  a_r4_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((main_rd | main_en_q) & ~EN_MASK) == 32'h0);

  // R5
  a_r5_ep_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |ep_evt_i |=> ((ep_stat_q & $past(ep_evt_i)) == $past(ep_evt_i)));

  // R6
  a_r6_sum_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_rd[SUM_BIT] |-> (|ep_stat_q && |ep_en_q));

  // R7
  a_r7_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |main_en_q);

  // R8
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT && |(main_evt_i & wdata_i & STAT_MASK)) |=>
      ((main_rd & $past(main_evt_i & wdata_i & STAT_MASK)) ==
       $past(main_evt_i & wdata_i & STAT_MASK)));
endmodule

bind usbd_irq_agg usbd_irq_agg_chk #(.N_EP(N_EP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .main_evt_i (main_evt_i),
  .ep_evt_i   (ep_evt_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .main_rd    (main_rd),
  .main_en_q  (main_en_q),
  .ep_stat_q  (ep_stat_q),
  .ep_en_q    (ep_en_q)
);

// File: tb/sim_usbd_irq_agg.sv
module sim_usbd_irq_agg;
  localparam int unsigned N_EP = 21;
  localparam logic [31:0] ENM  = 32'h0003_FFFF;
  localparam logic [31:0] STM  = 32'h0002_FFFF;
  localparam logic [31:0] EPM  = 32'h001F_FFFF;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] main_evt_i = '0, wdata_i = '0, rdata_o;
  logic [N_EP-1:0] ep_evt_i = '0;
  logic we_i = 1'b0, irq_o;
  logic [1:0] addr_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_stat = 0, m_en = 0, m_ep = 0, m_epen = 0;

  always #5 clk_i = ~clk_i;

  usbd_irq_agg #(.N_EP(N_EP)) u0 (.*);

  function automatic logic [31:0] exp_main();
    return (m_stat & STM) | ((|(m_ep & m_epen)) ? 32'h0001_0000 : 32'h0);
  endfunction

  function automatic logic exp_irq();
    return |(exp_main() & m_en);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, update model at posedge, sweep reads after
  task automatic step(logic [31:0] ev, logic [31:0] epev, logic we,
                      logic [1:0] ad, logic [31:0] wd);
    @(negedge clk_i);
    main_evt_i = ev; ep_evt_i = epev[N_EP-1:0];
    we_i = we; addr_i = ad; wdata_i = wd;
    @(posedge clk_i);
    m_stat = ((m_stat & ~((we && ad == 2'd0) ? wd : 32'h0)) | ev) & STM;
    if (we && ad == 2'd1) m_en = wd & ENM;
    m_ep = ((m_ep & ~((we && ad == 2'd2) ? wd : 32'h0)) | epev) & EPM;
    if (we && ad == 2'd3) m_epen = wd & EPM;
    #1;
    main_evt_i = '0; ep_evt_i = '0; we_i = 1'b0;
    addr_i = 2'd0; #1 check("R2 R4 R6 main status", rdata_o, exp_main());
    addr_i = 2'd1; #1 check("R9 main enable", rdata_o, m_en);
    addr_i = 2'd2; #1 check("R5 endpoint status", rdata_o, m_ep);
    addr_i = 2'd3; #1 check("R9 endpoint enable", rdata_o, m_epen);
    check("R7 irq", 32'(irq_o), 32'(exp_irq()));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #12 rst_ni = 1'b1;
    #1;
    // R1 reset state, R10 read mux
    for (int a = 0; a < 4; a++) begin
      addr_i = 2'(a); #1 check("R1 R10 reset value", rdata_o, 32'h0);
    end
    check("R1 irq after reset", 32'(irq_o), 32'h0);

    // R4 reserved positions and input bit 16 ignored
    step(32'hFFFF_FFFF & ~32'h0004_0000, 0, 1'b1, 2'd1, ~32'h0004_0000);
    step(32'hFFFC_0000 | 32'h0001_0000, 0, 1'b0, 2'd0, 0);
    check("R4 bit16 no store", 32'(m_stat[16]), 32'h0);
    step(0, 0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    check("R3 full clear", m_stat, 32'h0);

    // R8 set wins over clear, both registers
    step(32'h0000_0041, 32'h0000_0003, 1'b1, 2'd0, 32'h0000_0041);
    check("R8 main set wins", m_stat & 32'h41, 32'h41);
    step(0, 32'h0000_0001, 1'b1, 2'd2, 32'h0000_0003);
    check("R8 ep set wins", m_ep & 32'h3, 32'h1);

    // R3 zero bits keep value
    step(32'h0002_0300, 0, 1'b0, 2'd0, 0);
    step(0, 0, 1'b1, 2'd0, 32'h0000_0200);

    // R6 summary follows endpoint state, not clearable via main
    step(0, 32'h0010_0000, 1'b1, 2'd3, 32'h0010_0000);
    check("R6 summary set", 32'(exp_main()[16]), 32'h1);
    step(0, 0, 1'b1, 2'd0, 32'h0001_0000);
    step(0, 0, 1'b1, 2'd3, 32'h0);
    check("R6 summary masked", 32'(exp_main()[16]), 32'h0);
    step(0, 0, 1'b1, 2'd3, EPM);
    step(0, 0, 1'b1, 2'd2, EPM);
    check("R6 summary self-clears", 32'(exp_main()[16]), 32'h0);

    // R7 only summary enabled
    step(0, 32'h0000_0004, 1'b1, 2'd1, 32'h0001_0000);
    step(0, 0, 1'b1, 2'd2, 32'h0000_0004);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ev, ep, wd;
      ev = $urandom & $urandom & $urandom;
      ep = $urandom & $urandom & $urandom;
      wd = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : ($urandom & $urandom);
      step(ev, ep, 1'($urandom), 2'($urandom), wd);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule